// File: doc/BRIEF.md
# Codec Register Keyhole Access

This block lets a host reach the internal control and status registers of an audio codec through a few indirect registers. For a codec register write, the host first loads a 16-bit value and then writes a 7-bit register index with the direction flag cleared. For a read, the host writes only the index with the direction flag set. The address write is the trigger. After it, the block shows busy and ignores further host writes until the transfer ends.

The serial link is modelled at slot level. A one-cycle `frame_start_i` strobe marks each frame boundary. The block drives the command address and command data slots for the first frame after the trigger. It then watches the incoming status address and status data slots for the codec's reply. A write finishes one frame after its command frame. A read finishes when a valid status slot carries the requested index. If no such reply arrives within a bounded number of frames, the read ends with a timeout flag.

Top module: `codec_keyhole`

## Requirements
- R1: After reset, `busy_o`, `wr_done_o`, `rd_avail_o`, `timeout_o` and `cmd_valid_o` are 0, and `rdata_o` and both command slots are 0.
- R2: When idle, a pulse on `addr_we_i` starts a transfer, and `busy_o` is 1 from the following cycle. `rd_i`=1 selects a read and `rd_i`=0 selects a write that uses the last value loaded through `wdata_we_i`.
- R3: For the frame that begins at the first `frame_start_i` after the trigger, `cmd_valid_o` is 1. `cmd_addr_slot_o` is {bit 19 = read flag, bits 18:12 = index, bits 11:0 = 0}. `cmd_data_slot_o` holds the write data in bits 19:4 with bits 3:0 at 0 for a write, and is all zero for a read. Outside that frame, `cmd_valid_o` is 0 and both slots are 0.
- R4: A write clears `busy_o` and sets `wr_done_o` on the second `frame_start_i` after the one that opened its command frame.
- R5: During a read, once the command frame has ended, a cycle with `stat_valid_i`=1 and `stat_addr_slot_i[18:12]` equal to the index loads `stat_data_slot_i[19:4]` into `rdata_o`. In the next cycle `rd_avail_o` is 1 and `busy_o` is 0.
- R6: While a read is waiting, a status slot with a different index, or with `stat_valid_i`=0, has no effect.
- R7: If four `frame_start_i` strobes pass after the command frame with no matching reply, `timeout_o` is set and `busy_o` is cleared. `rd_avail_o` and `rdata_o` keep their values.
- R8: While `busy_o` is 1, pulses on `addr_we_i` and `wdata_we_i` are ignored.
- R9: A pulse on `rdata_re_i` clears `rd_avail_o` in the next cycle, and `rdata_o` keeps its value.
- R10: Starting a transfer clears `wr_done_o` and `timeout_o`. At most one of `busy_o`, `wr_done_o` and `timeout_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_we_i | input | 1 | Load the write-data register |
| wdata_i | input | 16 | Write data for the codec |
| addr_we_i | input | 1 | Address write; triggers a transfer |
| addr_i | input | 7 | Codec register index |
| rd_i | input | 1 | 1 = read, 0 = write, sampled with `addr_we_i` |
| rdata_re_i | input | 1 | Host consumes the returned data |
| frame_start_i | input | 1 | Frame boundary strobe |
| stat_valid_i | input | 1 | Valid tag of the incoming status slots |
| stat_addr_slot_i | input | 20 | Incoming status address slot |
| stat_data_slot_i | input | 20 | Incoming status data slot |
| cmd_valid_o | output | 1 | Command slots valid in the current frame |
| cmd_addr_slot_o | output | 20 | Outgoing command address slot |
| cmd_data_slot_o | output | 20 | Outgoing command data slot |
| rdata_o | output | 16 | Data returned by the codec |
| busy_o | output | 1 | Transfer pending |
| wr_done_o | output | 1 | Codec write finished |
| rd_avail_o | output | 1 | Read data available |
| timeout_o | output | 1 | Read ended with no reply |

## Verification
The properties take for granted that `frame_start_i` and `stat_valid_i` are single-cycle pulses. They also assume that the host raises `rdata_re_i` only while no transfer is pending, since a reply accepted in the same cycle would take precedence over the clear. The stimulus keeps to these rules. Each strobe lasts one cycle and is issued from its own task. Frame strobes and status pulses never share a cycle. The data-consume pulse is issued only after `busy_o` has dropped. Random read latencies are drawn on both sides of the timeout window, and decoy replies with a wrong index or a cleared tag are sent before the real one.

// File: rtl/codec_keyhole_pkg.sv
package codec_keyhole_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SENT,
    ST_WR_HOLD,
    ST_RD_WAIT
  } kh_state_e;
endpackage

// File: rtl/kh_host_regs.sv
module kh_host_regs #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wdata_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              addr_we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic [IDX_W-1:0]  idx_q_o,
  output logic              rd_q_o,
  output logic              start_o
);
  assign start_o = addr_we_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      idx_q_o  <= '0;
      rd_q_o   <= 1'b0;
    end else begin
      if (wdata_we_i && !busy_i) data_q_o <= wdata_i;
      if (start_o) begin
        idx_q_o <= addr_i;
        rd_q_o  <= rd_i;
      end
    end
  end
endmodule

// File: rtl/kh_seq.sv
module kh_seq
  import codec_keyhole_pkg::*;
#(
  parameter int TMO_FRAMES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_i,
  input  logic frame_start_i,
  input  logic match_i,
  output logic busy_o,
  output logic cmd_valid_o,
  output logic wr_done_o,
  output logic timeout_o,
  output logic rd_hit_o
);
  localparam int CNT_W = $clog2(TMO_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_FRAMES - 1);

  kh_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_done_d, timeout_d;

  assign busy_o      = (state_q != ST_IDLE);
  assign cmd_valid_o = (state_q == ST_SENT);
  assign rd_hit_o    = (state_q == ST_RD_WAIT) && match_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wr_done_d = wr_done_o;
    timeout_d = timeout_o;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_ARMED;
        wr_done_d = 1'b0;
        timeout_d = 1'b0;
      end
      ST_ARMED: if (frame_start_i) state_d = ST_SENT;
      ST_SENT: if (frame_start_i) begin
        state_d = rd_i ? ST_RD_WAIT : ST_WR_HOLD;
        cnt_d   = '0;
      end
      ST_WR_HOLD: if (frame_start_i) begin
        state_d   = ST_IDLE;
        wr_done_d = 1'b1;
      end
      ST_RD_WAIT: begin
        if (match_i) begin
          state_d = ST_IDLE;
        end else if (frame_start_i) begin
          if (cnt_q == CNT_LAST) begin
            state_d   = ST_IDLE;
            timeout_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      wr_done_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      wr_done_o <= wr_done_d;
      timeout_o <= timeout_d;
    end
  end
endmodule

// File: rtl/kh_slot_fmt.sv
module kh_slot_fmt #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20
) (
  input  logic              valid_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SLOT_W-1:0] addr_slot_o,
  output logic [SLOT_W-1:0] data_slot_o
);
  localparam int IDX_LSB = SLOT_W - 1 - IDX_W;
  localparam int PAD_W   = SLOT_W - DATA_W;

  always_comb begin
    addr_slot_o = '0;
    data_slot_o = '0;
    if (valid_i) begin
      addr_slot_o = {rd_i, idx_i, {IDX_LSB{1'b0}}};
      if (!rd_i) data_slot_o = {data_i, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/kh_resp.sv
module kh_resp #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_valid_i,
  input  logic [SLOT_W-1:0] stat_addr_slot_i,
  input  logic [SLOT_W-1:0] stat_data_slot_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hit_i,
  input  logic              rdata_re_i,
  output logic              match_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              avail_o
);
  localparam int IDX_LSB = SLOT_W - 1 - IDX_W;
  localparam int PAD_W   = SLOT_W - DATA_W;

  logic [IDX_W-1:0] stat_idx;
  logic             unused_bits;

  assign stat_idx    = stat_addr_slot_i[SLOT_W-2 -: IDX_W];
  assign match_o     = stat_valid_i && (stat_idx == idx_i);
  assign unused_bits = ^{stat_addr_slot_i[SLOT_W-1], stat_addr_slot_i[IDX_LSB-1:0],
                         stat_data_slot_i[PAD_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      avail_o <= 1'b0;
    end else if (hit_i) begin
      rdata_o <= stat_data_slot_i[SLOT_W-1 -: DATA_W];
      avail_o <= 1'b1;
    end else if (rdata_re_i) begin
      avail_o <= 1'b0;
    end
  end
endmodule

// File: rtl/codec_keyhole.sv
module codec_keyhole #(
  parameter int IDX_W      = 7,
  parameter int DATA_W     = 16,
  parameter int SLOT_W     = 20,
  parameter int TMO_FRAMES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wdata_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              addr_we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              rd_i,
  input  logic              rdata_re_i,
  input  logic              frame_start_i,
  input  logic              stat_valid_i,
  input  logic [SLOT_W-1:0] stat_addr_slot_i,
  input  logic [SLOT_W-1:0] stat_data_slot_i,
  output logic              cmd_valid_o,
  output logic [SLOT_W-1:0] cmd_addr_slot_o,
  output logic [SLOT_W-1:0] cmd_data_slot_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              wr_done_o,
  output logic              rd_avail_o,
  output logic              timeout_o
);
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rd_q, start, match, rd_hit;

  kh_host_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_o),
    .wdata_we_i (wdata_we_i),
    .wdata_i    (wdata_i),
    .addr_we_i  (addr_we_i),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .data_q_o   (data_q),
    .idx_q_o    (idx_q),
    .rd_q_o     (rd_q),
    .start_o    (start)
  );

  kh_seq #(.TMO_FRAMES(TMO_FRAMES)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .rd_i          (rd_q),
    .frame_start_i (frame_start_i),
    .match_i       (match),
    .busy_o        (busy_o),
    .cmd_valid_o   (cmd_valid_o),
    .wr_done_o     (wr_done_o),
    .timeout_o     (timeout_o),
    .rd_hit_o      (rd_hit)
  );

  kh_slot_fmt #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_fmt (
    .valid_i     (cmd_valid_o),
    .rd_i        (rd_q),
    .idx_i       (idx_q),
    .data_i      (data_q),
    .addr_slot_o (cmd_addr_slot_o),
    .data_slot_o (cmd_data_slot_o)
  );

  kh_resp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_resp (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .stat_valid_i     (stat_valid_i),
    .stat_addr_slot_i (stat_addr_slot_i),
    .stat_data_slot_i (stat_data_slot_i),
    .idx_i            (idx_q),
    .hit_i            (rd_hit),
    .rdata_re_i       (rdata_re_i),
    .match_o          (match),
    .rdata_o          (rdata_o),
    .avail_o          (rd_avail_o)
  );
endmodule

// File: rtl/codec_keyhole_chk.sv
module codec_keyhole_chk #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_we_i,
  input logic              rdata_re_i,
  input logic              cmd_valid_o,
  input logic [SLOT_W-1:0] cmd_addr_slot_o,
  input logic [SLOT_W-1:0] cmd_data_slot_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              busy_o,
  input logic              wr_done_o,
  input logic              rd_avail_o,
  input logic              timeout_o,
  input logic [IDX_W-1:0]  idx_q
);
  localparam int PAD_W = SLOT_W - DATA_W;

  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && addr_we_i |=> $stable(idx_q)); // R8
  AST_CMD_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o); // R3
  AST_NO_CMD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_addr_slot_o == '0) && (cmd_data_slot_o == '0)); // R3
  AST_WR_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_addr_slot_o[SLOT_W-1] |-> cmd_data_slot_o[PAD_W-1:0] == '0); // R3
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, wr_done_o, timeout_o})); // R10
  AST_AVAIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_re_i && !busy_o |=> !rd_avail_o); // R9
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rdata_o)); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_done_o) |-> $fell(busy_o)); // R4
  AST_TMO_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $fell(busy_o) && $stable(rd_avail_o)); // R7
endmodule

bind codec_keyhole codec_keyhole_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .addr_we_i       (addr_we_i),
  .rdata_re_i      (rdata_re_i),
  .cmd_valid_o     (cmd_valid_o),
  .cmd_addr_slot_o (cmd_addr_slot_o),
  .cmd_data_slot_o (cmd_data_slot_o),
  .rdata_o         (rdata_o),
  .busy_o          (busy_o),
  .wr_done_o       (wr_done_o),
  .rd_avail_o      (rd_avail_o),
  .timeout_o       (timeout_o),
  .idx_q           (idx_q)
);

// File: tb/codec_keyhole_tb_top.sv
module codec_keyhole_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_TXN      = 150;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wdata_we_i = 0, addr_we_i = 0, rd_i = 0, rdata_re_i = 0;
  logic        frame_start_i = 0, stat_valid_i = 0;
  logic [15:0] wdata_i = '0;
  logic [6:0]  addr_i = '0;
  logic [19:0] stat_addr_slot_i = '0, stat_data_slot_i = '0;
  logic        cmd_valid_o, busy_o, wr_done_o, rd_avail_o, timeout_o;
  logic [19:0] cmd_addr_slot_o, cmd_data_slot_o;
  logic [15:0] rdata_o;

  int total = 0, bad = 0;
  logic [15:0] exp_rdata = '0;
  logic        exp_avail = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  codec_keyhole dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr_slot(logic rd, logic [6:0] idx);
    return {rd, idx, 12'h000};
  endfunction

  function automatic logic [19:0] exp_data_slot(logic rd, logic [15:0] d);
    return rd ? 20'h0 : {d, 4'h0};
  endfunction

  task automatic put_wdata(logic [15:0] d);
    @(negedge clk_i); wdata_we_i = 1; wdata_i = d;
    @(negedge clk_i); wdata_we_i = 0;
  endtask

  task automatic put_addr(logic rd, logic [6:0] idx);
    @(negedge clk_i); addr_we_i = 1; rd_i = rd; addr_i = idx;
    @(negedge clk_i); addr_we_i = 0;
  endtask

  task automatic frame;
    @(negedge clk_i); frame_start_i = 1;
    @(negedge clk_i); frame_start_i = 0;
  endtask

  task automatic reply(logic v, logic [6:0] idx, logic [15:0] d);
    @(negedge clk_i);
    stat_valid_i = v;
    stat_addr_slot_i = {1'b0, idx, 12'($urandom)};
    stat_data_slot_i = {d, 4'($urandom)};
    @(negedge clk_i); stat_valid_i = 0;
  endtask

  task automatic consume;
    @(negedge clk_i); rdata_re_i = 1;
    @(negedge clk_i); rdata_re_i = 0;
    exp_avail = 0;
    chk("R9 avail cleared", rd_avail_o, 0);
    chk("R9 rdata held", rdata_o, exp_rdata);
  endtask

  task automatic do_write(logic [15:0] d, logic [6:0] idx, bit poke);
    put_wdata(d);
    put_addr(0, idx);
    chk("R2 busy after trigger", busy_o, 1);
    chk("R10 done cleared", {wr_done_o, timeout_o}, 0);
    if (poke) begin
      put_addr(1, idx ^ 7'h55);
      put_wdata(~d);
    end
    frame;
    chk("R3 cmd valid", cmd_valid_o, 1);
    chk("R3 addr slot", cmd_addr_slot_o, exp_addr_slot(0, idx));
    chk(poke ? "R8 data slot" : "R3 data slot", cmd_data_slot_o, exp_data_slot(0, d));
    frame;
    chk("R3 cmd dropped", {cmd_valid_o, cmd_addr_slot_o}, 0);
    chk("R4 still busy", busy_o, 1);
    frame;
    chk("R4 busy clear", busy_o, 0);
    chk("R4 done set", wr_done_o, 1);
  endtask

  task automatic do_read(logic [6:0] idx, logic [15:0] d, int delay, bit decoy);
    put_addr(1, idx);
    chk("R2 busy after read trigger", busy_o, 1);
    chk("R10 flags cleared", {wr_done_o, timeout_o}, 0);
    frame;
    chk("R3 read cmd valid", cmd_valid_o, 1);
    chk("R3 read addr slot", cmd_addr_slot_o, exp_addr_slot(1, idx));
    chk("R3 read data slot", cmd_data_slot_o, 0);
    frame;
    for (int j = 0; j < 4; j++) begin
      if (j == delay) begin
        if (decoy) begin
          reply(1, idx ^ 7'h01, ~d);
          reply(0, idx, ~d);
          chk("R6 decoy ignored", {busy_o, rd_avail_o, rdata_o}, {1'b1, exp_avail, exp_rdata});
        end
        reply(1, idx, d);
        exp_rdata = d;
        exp_avail = 1;
        chk("R5 busy clear", busy_o, 0);
        chk("R5 avail", rd_avail_o, 1);
        chk("R5 rdata", rdata_o, d);
        return;
      end
      frame;
      if (j < 3) chk("R7 waiting", busy_o, 1);
    end
    chk("R7 timeout", {busy_o, timeout_o}, 2'b01);
    chk("R7 avail kept", {rd_avail_o, rdata_o}, {exp_avail, exp_rdata});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk_i);
    chk("R1 reset flags", {busy_o, wr_done_o, rd_avail_o, timeout_o, cmd_valid_o}, 0);
    chk("R1 reset data", {rdata_o, cmd_addr_slot_o, cmd_data_slot_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    do_write(16'hBEEF, 7'h7F, 1);
    do_write(16'h0001, 7'h00, 0);
    do_read(7'h26, 16'hA5C3, 0, 1);
    do_read(7'h26, 16'h1111, 3, 0);
    do_read(7'h40, 16'h2222, 9, 0);
    consume;
    do_read(7'h11, 16'h3333, 4, 0);
    for (int t = 0; t < N_TXN; t++) begin
      if ($urandom_range(1, 0) == 1)
        do_write(16'($urandom), 7'($urandom), bit'($urandom_range(1, 0)));
      else
        do_read(7'($urandom), 16'($urandom), int'($urandom_range(5, 0)),
                bit'($urandom_range(1, 0)));
      if (exp_avail && $urandom_range(3, 0) == 0) consume;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule